// File: doc/BRIEF.md
# HALT Entry and Wake Controller

This block sits beside the decoder of a small 8-bit processor core and decides what the HALT opcode actually does. When the decoder presents a HALT request, the block looks at the master interrupt enable, the countdown of a pending interrupt-enable, the OR of the requested-and-enabled interrupt lines, and a strap that selects the later colour variant of the core. From these it chooses one of three outcomes: enter the halt state, skip the halt and freeze the program counter for one fetch (mono variant), or skip the halt and request a short idle (colour variant).

Once halted, the core samples the interrupt lines once per machine cycle; one clock of this block is one machine cycle. Any requested and enabled interrupt wakes the core, whether the master enable is set or not. The block also reproduces the secondary quirk of the first wake-up check. A halt entered with nothing pending, or entered with the master enable off, arms a flag. If that first check then sees a request, a halt with interrupts enabled is reported as running twice, and a halt with interrupts disabled freezes the program counter so that the following byte is read again.

Top module: `halt_ctl`

## Requirements
- R1: After a synchronous active-high reset, `halted`, `pc_hold`, `delay_busy`, `wake` and `repeat_halt` are all 0.
- R2: A `halt_req` accepted while `irq_any`=1, `ei_delay`=0 and `ime`=0 (the skip case) never sets `halted`.
- R3: In the skip case with `color_mode`=1, `delay_busy` is high for exactly DELAY_CYC (default 4) cycles, starting in the cycle after `halt_req`. `pc_hold` is not set.
- R4: In the skip case with `color_mode`=0, `pc_hold` rises in the cycle after `halt_req` and stays high until a clock edge at which `fetch` is sampled high. It is low in the cycle after that edge.
- R5: An accepted `halt_req` outside the skip case sets `halted` in the following cycle.
- R6: While halted, a wake-up check that samples `irq_any`=1 clears `halted` and pulses `wake` for one cycle, both visible in the cycle after that edge, for either value of `ime`.
- R7: With `color_mode`=1 at entry, the first wake-up check happens at the first clock edge after the entry edge.
- R8: With `color_mode`=0 at entry, the first edge after entry performs no check, so `halted` stays high whatever `irq_any` is. Checking starts at the second edge.
- R9: The secondary flag is armed at entry when `irq_any`=0 or `ime`=0. If the first check then sees `irq_any`=1 with `ime`=1, `repeat_halt` pulses together with `wake`.
- R10: If the armed first check sees `irq_any`=1 with `ime`=0, `pc_hold` is set along with `wake`, and it clears as in R4.
- R11: Checks after the first, and first checks when the flag is not armed, produce only `wake`, with no `repeat_halt` and no new `pc_hold`.
- R12: `halt_req` is ignored while `halted` or `delay_busy` is high. Outputs evolve exactly as if it were 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, one machine cycle per edge |
| rst | input | 1 | Synchronous active-high reset |
| halt_req | input | 1 | Decoder reports a HALT opcode this cycle |
| fetch | input | 1 | Opcode fetch happens this cycle; consumes a pending PC hold |
| ime | input | 1 | Master interrupt enable |
| ei_delay | input | EID_W (2) | Countdown of a pending interrupt enable; 0 means none pending |
| irq_any | input | 1 | OR of requested and enabled interrupt lines |
| color_mode | input | 1 | 1 selects the colour-variant behaviour |
| halted | output | 1 | Core is in the halt state |
| pc_hold | output | 1 | Suppress the PC increment on the next opcode fetch |
| delay_busy | output | 1 | Extra idle cycles requested instead of a halt |
| wake | output | 1 | One-cycle pulse on leaving the halt state |
| repeat_halt | output | 1 | One-cycle pulse: the halt executes a second time |

## Verification
A stale skip-once flag moves the first observed `wake` by exactly one cycle. A wrongly latched secondary flag shows up as a missing or spurious `repeat_halt` or `pc_hold` in the cycle right after the first check. A delay counter loaded with the wrong value shifts the falling edge of `delay_busy`. A hold flag that is not cleared stays high past the consuming fetch. Because every one of these faults appears at the ports within one or two cycles of its cause, the bench compares all outputs on every clock against a behavioural model.

// File: rtl/halt_ctl.sv
module halt_ctl #(
  parameter int DELAY_CYC = 4,
  parameter int EID_W     = 2
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             halt_req,
  input  logic             fetch,
  input  logic             ime,
  input  logic [EID_W-1:0] ei_delay,
  input  logic             irq_any,
  input  logic             color_mode,
  output logic             halted,
  output logic             pc_hold,
  output logic             delay_busy,
  output logic             wake,
  output logic             repeat_halt
);
  localparam int CW = $clog2(DELAY_CYC + 1);

  logic          halted_q, skip1_q, first_q, armed_q, hold_q, wake_q, rep_q;
  logic [CW-1:0] dly_q;

  logic accept, skip, enter, check, hit, bug_hit, set_hold;

  assign delay_busy = (dly_q != '0);
  assign accept     = halt_req && !halted_q && !delay_busy;
  assign skip       = irq_any && (ei_delay == '0) && !ime;
  assign enter      = accept && !skip;
  assign check      = halted_q && !skip1_q;
  assign hit        = check && irq_any;
  assign bug_hit    = hit && first_q && armed_q;
  assign set_hold   = (accept && skip && !color_mode) || (bug_hit && !ime);

  always_ff @(posedge clk) begin
    if (rst) begin
      halted_q <= 1'b0;
      skip1_q  <= 1'b0;
      first_q  <= 1'b0;
      armed_q  <= 1'b0;
      hold_q   <= 1'b0;
      wake_q   <= 1'b0;
      rep_q    <= 1'b0;
      dly_q    <= '0;
    end else begin
      wake_q <= hit;
      rep_q  <= bug_hit && ime;

      if (enter) begin
        halted_q <= 1'b1;
        skip1_q  <= !color_mode;
        first_q  <= 1'b1;
        armed_q  <= !irq_any || !ime;
      end else if (halted_q) begin
        if (skip1_q) begin
          skip1_q <= 1'b0;
        end else begin
          first_q <= 1'b0;
          armed_q <= 1'b0;
          if (irq_any) halted_q <= 1'b0;
        end
      end

      if (accept && skip && color_mode) dly_q <= DELAY_CYC[CW-1:0];
      else if (dly_q != '0)             dly_q <= dly_q - CW'(1);

      if (set_hold)   hold_q <= 1'b1;
      else if (fetch) hold_q <= 1'b0;
    end
  end

  assign halted      = halted_q;
  assign pc_hold     = hold_q;
  assign wake        = wake_q;
  assign repeat_halt = rep_q;
endmodule

module halt_ctl_chk #(
  parameter int EID_W = 2
) (
  input logic             clk,
  input logic             rst,
  input logic             halt_req,
  input logic             fetch,
  input logic             ime,
  input logic [EID_W-1:0] ei_delay,
  input logic             irq_any,
  input logic             color_mode,
  input logic             halted,
  input logic             pc_hold,
  input logic             delay_busy,
  input logic             wake,
  input logic             repeat_halt
);
  assert_no_halt_on_skip_R2: assert property (@(posedge clk) disable iff (rst)
    (halt_req && !halted && !delay_busy && irq_any && ei_delay == '0 && !ime) |=> !halted);

  assert_delay_not_halted_R3: assert property (@(posedge clk) disable iff (rst)
    delay_busy |-> !halted);

  assert_enter_R5: assert property (@(posedge clk) disable iff (rst)
    (halt_req && !halted && !delay_busy && !(irq_any && ei_delay == '0 && !ime)) |=> halted);

  assert_wake_exit_R6: assert property (@(posedge clk) disable iff (rst)
    wake |-> (!halted && $past(halted)));

  assert_mono_skip_check_R8: assert property (@(posedge clk) disable iff (rst)
    ($rose(halted) && $past(!color_mode)) |=> halted);

  assert_repeat_with_wake_R9: assert property (@(posedge clk) disable iff (rst)
    repeat_halt |-> wake);

  assert_single_wake_R6: assert property (@(posedge clk) disable iff (rst)
    wake |=> !wake);
endmodule

bind halt_ctl halt_ctl_chk #(.EID_W(EID_W)) chk_i (.*);

// File: tb/halt_ctl_tb.sv
module halt_ctl_tb_top;
  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       halt_req = 0, fetch = 0, ime = 0, irq_any = 0, color_mode = 0;
  logic [1:0] ei_delay = 0;
  logic       halted, pc_hold, delay_busy, wake, repeat_halt;

  int checks = 0, errors = 0;
  string cur_req = "R1";

  int m_halt, m_skip1, m_first, m_armed, m_hold, m_wake, m_rep, m_dly;

  always #10 clk = ~clk;

  halt_ctl dut_i (
    .clk(clk), .rst(rst), .halt_req(halt_req), .fetch(fetch), .ime(ime),
    .ei_delay(ei_delay), .irq_any(irq_any), .color_mode(color_mode),
    .halted(halted), .pc_hold(pc_hold), .delay_busy(delay_busy),
    .wake(wake), .repeat_halt(repeat_halt)
  );

  task automatic model_edge();
    bit can_take, skip_case, chk, got, bug;
    int nh, ns, nf, na;
    if (rst) begin
      m_halt = 0; m_skip1 = 0; m_first = 0; m_armed = 0;
      m_hold = 0; m_wake = 0; m_rep = 0; m_dly = 0;
      return;
    end
    can_take  = halt_req && m_halt == 0 && m_dly == 0;
    skip_case = irq_any && ei_delay == 0 && !ime;
    chk = (m_halt != 0) && (m_skip1 == 0);
    got = chk && irq_any;
    bug = got && m_first != 0 && m_armed != 0;
    nh = m_halt; ns = m_skip1; nf = m_first; na = m_armed;
    if (can_take && !skip_case) begin
      nh = 1; ns = color_mode ? 0 : 1; nf = 1; na = (!irq_any || !ime) ? 1 : 0;
    end else if (m_halt != 0) begin
      if (m_skip1 != 0) ns = 0;
      else begin nf = 0; na = 0; if (irq_any) nh = 0; end
    end
    if ((can_take && skip_case && !color_mode) || (bug && !ime)) m_hold = 1;
    else if (fetch) m_hold = 0;
    if (can_take && skip_case && color_mode) m_dly = 4;
    else if (m_dly > 0) m_dly--;
    m_wake = got ? 1 : 0;
    m_rep  = (bug && ime) ? 1 : 0;
    m_halt = nh; m_skip1 = ns; m_first = nf; m_armed = na;
  endtask

  task automatic cmp(string nm, logic act, int exp);
    checks++;
    if (act !== exp[0]) begin
      errors++;
      $display("FAIL %s %s actual=%0b expected=%0d t=%0t", cur_req, nm, act, exp, $time);
    end
  endtask

  task automatic step(bit hr = 0, bit fe = 0);
    halt_req = hr; fetch = fe;
    @(posedge clk);
    model_edge();
    @(negedge clk);
    halt_req = 0; fetch = 0;
    cmp("halted", halted, m_halt);
    cmp("pc_hold", pc_hold, m_hold);
    cmp("delay_busy", delay_busy, m_dly != 0 ? 1 : 0);
    cmp("wake", wake, m_wake);
    cmp("repeat_halt", repeat_halt, m_rep);
  endtask

  task automatic settle();
    irq_any = 0;
    for (int i = 0; i < 3; i++) step(0, 1);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    errors++;
    $display("FAIL watchdog expired");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    @(negedge clk);
    step(); step();
    cur_req = "R1"; step();
    rst = 0;

    cur_req = "R3";
    color_mode = 1; irq_any = 1; ime = 0; ei_delay = 0;
    step(1);
    cur_req = "R12";
    step(1);
    cur_req = "R3";
    for (int i = 0; i < 5; i++) step();
    settle();

    cur_req = "R4";
    color_mode = 0; irq_any = 1; ime = 0;
    step(1);
    cur_req = "R2";
    for (int i = 0; i < 3; i++) step();
    cur_req = "R4";
    step(0, 1); step();
    settle();

    cur_req = "R8";
    color_mode = 0; irq_any = 0; ime = 1;
    step(1);
    irq_any = 1; step();
    cur_req = "R9";
    step(); step();
    settle();

    cur_req = "R5";
    color_mode = 0; irq_any = 0; ime = 1;
    step(1);
    cur_req = "R12";
    step(1); step(1);
    cur_req = "R11";
    step(); step();
    irq_any = 1;
    cur_req = "R6";
    step(); step();
    settle();

    cur_req = "R7";
    color_mode = 1; irq_any = 0; ime = 0;
    step(1);
    irq_any = 1;
    cur_req = "R10";
    step(); step(); step();
    step(0, 1); step();
    settle();

    cur_req = "R10";
    color_mode = 1; irq_any = 1; ime = 0; ei_delay = 1;
    step(1); step(); step();
    step(0, 1);
    ei_delay = 0;
    settle();

    cur_req = "R11";
    color_mode = 1; irq_any = 1; ime = 1;
    step(1); step(); step();
    settle();

    cur_req = "R6";
    color_mode = 1; irq_any = 0; ime = 0;
    step(1);
    for (int i = 0; i < 4; i++) step();
    irq_any = 1;
    cur_req = "R11";
    step(); step();
    settle();

    cur_req = "R11";
    color_mode = 0; irq_any = 1; ime = 1; ei_delay = 2;
    step(1); step(); step(); step();
    ei_delay = 0;
    settle();

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule